// File: doc/BRIEF.md
# Control-Transfer Next-PC Stage

This block is one pipeline stage that works out where a 16-bit processor fetches next after a control-transfer instruction. Each accepted item carries an instruction word, the program counter already advanced past that instruction, the value of the base register the instruction names, and the current sign flags. The stage decides whether the instruction is a conditional branch, a register jump (return included), a PC-relative call, a register call, or anything else. It then produces the next fetch address, and for calls it also produces a request to write the return address into register 7.

Items enter and leave through valid/ready handshakes, with one output register in between. An item is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so the stage sustains one item per cycle. While the consumer holds `out_ready` low, the held result does not change and no new item is accepted. The index of the base register is decoded combinationally, so a register file can supply `in_base` in the same cycle.

Top module: `nextpc_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An item is accepted on an edge where `in_valid && in_ready`, and its result appears on the outputs at the following negative phase. While `out_valid && !out_ready`, all outputs hold their values.
- R2: While `rst_n` is low and after it is released, `out_valid` is 0 and `in_ready` is 1. A reset in the middle of operation discards the held result.
- R3: Opcode `instr[15:12]` = 0000 is a branch. The mask in `instr[11:9]` selects n, z, p, and the flags arrive as `in_flags[2]`=n, `in_flags[1]`=z, `in_flags[0]`=p. The branch is taken when any masked flag is set, and then the next PC is `pc_inc` plus `instr[8:0]` sign-extended.
- R4: A branch with mask 000 is never taken. Mask 111 is taken whenever any flag is set. A branch that is not taken gives next PC = `pc_inc`. No branch raises the link write.
- R5: Opcode 1100 is a jump: next PC = `in_base`, with no link write. `base_idx` always equals `instr[8:6]`, so a return (base index 7) behaves as a jump through register 7.
- R6: Opcode 0100 with `instr[11]`=1 is a relative call: next PC = `pc_inc` plus `instr[10:0]` sign-extended, `out_link_we`=1, and `out_link_data` = `pc_inc`.
- R7: Opcode 0100 with `instr[11]`=0 is a register call: next PC = `in_base`, `out_link_we`=1, and `out_link_data` = `pc_inc`. A call through register 7 jumps to the value register 7 held before the call.
- R8: Every other opcode gives next PC = `pc_inc` and `out_link_we`=0.
- R9: Target addition wraps modulo 2^PC_W, both below address 0 and above the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Stage can accept an item this cycle |
| in_instr | input | 16 | Instruction word |
| in_pc_inc | input | PC_W | Address of the instruction plus one |
| in_base | input | PC_W | Value of the register named by `base_idx` |
| in_flags | input | 3 | Sign flags {n, z, p} |
| base_idx | output | 3 | Base register index decoded from `in_instr[8:6]` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | PC_W | Next fetch address |
| out_link_we | output | 1 | Write `out_link_data` into register 7 |
| out_link_data | output | PC_W | Return address for calls |

## Verification
The bench builds the stage with the default PC_W of 16. At that width, the largest forward and backward offsets of both the 9-bit and the 11-bit fields can push the target past address 0 and past 0xFFFF, so the wrap rule is exercised directly. The same width covers every mask and flag pairing that matters, including a call through register 7. Directed sequences hold `out_ready` low to show that the output stays stable and that input is refused, and apply reset while a result is held.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int ILEN = 16;
  localparam logic [3:0] OPC_BRANCH = 4'b0000;
  localparam logic [3:0] OPC_JUMP   = 4'b1100;
  localparam logic [3:0] OPC_CALL   = 4'b0100;
  localparam int BR_OFF_W   = 9;
  localparam int CALL_OFF_W = 11;

  typedef enum logic [2:0] {
    XFER_SEQ,
    XFER_BRANCH,
    XFER_JUMP,
    XFER_CALL_REL,
    XFER_CALL_REG
  } xfer_e;
endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
(
  input  logic [ILEN-1:0]       instr,
  output xfer_e                 kind,
  output logic [2:0]            mask,
  output logic [2:0]            base_idx,
  output logic [BR_OFF_W-1:0]   off_br,
  output logic [CALL_OFF_W-1:0] off_call
);
  logic [3:0] opc;
  assign opc      = instr[15:12];
  assign mask     = instr[11:9];
  assign base_idx = instr[8:6];
  assign off_br   = instr[BR_OFF_W-1:0];
  assign off_call = instr[CALL_OFF_W-1:0];

  always_comb begin
    unique case (opc)
      OPC_BRANCH: kind = XFER_BRANCH;
      OPC_JUMP:   kind = XFER_JUMP;
      OPC_CALL:   kind = instr[11] ? XFER_CALL_REL : XFER_CALL_REG;
      default:    kind = XFER_SEQ;
    endcase
  end
endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond (
  input  logic [2:0] mask,
  input  logic [2:0] flags,
  output logic       taken
);
  assign taken = |(mask & flags);
endmodule

// File: rtl/nextpc_reltarget.sv
module nextpc_reltarget #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 9
) (
  input  logic [PC_W-1:0]  pc_inc,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - OFF_W;
  logic [PC_W-1:0] off_ext;
  assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
  assign target  = pc_inc + off_ext;
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ILEN-1:0] in_instr,
  input  logic [PC_W-1:0] in_pc_inc,
  input  logic [PC_W-1:0] in_base,
  input  logic [2:0]      in_flags,
  output logic [2:0]      base_idx,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PC_W-1:0] out_next_pc,
  output logic            out_link_we,
  output logic [PC_W-1:0] out_link_data
);
  xfer_e                 kind;
  logic [2:0]            mask;
  logic [BR_OFF_W-1:0]   off_br;
  logic [CALL_OFF_W-1:0] off_call;
  logic                  taken;
  logic [PC_W-1:0]       br_target, call_target;
  logic [PC_W-1:0]       nxt_pc;
  logic                  nxt_we;
  logic                  accept;

  nextpc_decode u_dec (
    .instr(in_instr), .kind(kind), .mask(mask), .base_idx(base_idx),
    .off_br(off_br), .off_call(off_call)
  );

  nextpc_cond u_cond (.mask(mask), .flags(in_flags), .taken(taken));

  nextpc_reltarget #(.PC_W(PC_W), .OFF_W(BR_OFF_W)) u_br_tgt (
    .pc_inc(in_pc_inc), .off(off_br), .target(br_target)
  );

  nextpc_reltarget #(.PC_W(PC_W), .OFF_W(CALL_OFF_W)) u_call_tgt (
    .pc_inc(in_pc_inc), .off(off_call), .target(call_target)
  );

  always_comb begin
    nxt_pc = in_pc_inc;
    nxt_we = 1'b0;
    unique case (kind)
      XFER_BRANCH:   nxt_pc = taken ? br_target : in_pc_inc;
      XFER_JUMP:     nxt_pc = in_base;
      XFER_CALL_REL: begin nxt_pc = call_target; nxt_we = 1'b1; end
      XFER_CALL_REG: begin nxt_pc = in_base;     nxt_we = 1'b1; end
      default:       nxt_pc = in_pc_inc;
    endcase
  end

  logic            valid_q, we_q;
  logic [PC_W-1:0] pc_q, link_q;

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      pc_q    <= '0;
      link_q  <= '0;
    end else begin
      if (in_ready) valid_q <= in_valid;
      if (accept) begin
        pc_q   <= nxt_pc;
        we_q   <= nxt_we;
        link_q <= in_pc_inc;
      end
    end
  end

  assign out_valid     = valid_q;
  assign out_next_pc   = pc_q;
  assign out_link_we   = valid_q && we_q;
  assign out_link_data = link_q;

  // R1
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc)
                                   && $stable(out_link_we) && $stable(out_link_data)));

  // R5
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[15:12] == OPC_JUMP)
      |=> (out_next_pc == $past(in_base) && !out_link_we));

  // R4
  never_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[15:9] == 7'b0000_000)
      |=> (out_next_pc == $past(in_pc_inc)));

  // R7
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[15:12] == OPC_CALL)
      |=> (out_link_we && out_link_data == $past(in_pc_inc)));

  // R8
  plain_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[15:12] != OPC_CALL)
      |=> !out_link_we);
endmodule

// File: tb/tb_nextpc_unit.sv
module tb_nextpc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] pc;
    logic [15:0] base;
    logic [2:0]  fl;
    logic [15:0] exp_pc;
    logic        exp_we;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{16'h05FD, 16'h3006, 16'h0000, 3'b010, 16'h3003, 1'b0, 4'd3}, // R3 z taken, -3
    '{16'h05FD, 16'h3006, 16'h0000, 3'b001, 16'h3006, 1'b0, 4'd4}, // R4 not taken
    '{16'h0FFF, 16'h3013, 16'h0000, 3'b100, 16'h3012, 1'b0, 4'd4}, // R4 mask 111
    '{16'h0005, 16'h3010, 16'h0000, 3'b111, 16'h3010, 1'b0, 4'd4}, // R4 mask 000
    '{16'h02FF, 16'h1000, 16'h0000, 3'b001, 16'h10FF, 1'b0, 4'd3}, // R3 max fwd
    '{16'h0900, 16'h0080, 16'h0000, 3'b100, 16'hFF80, 1'b0, 4'd9}, // R9 wrap low
    '{16'hC180, 16'h3009, 16'h300C, 3'b000, 16'h300C, 1'b0, 4'd5}, // R5 jump
    '{16'hC1C0, 16'h3014, 16'h3012, 3'b010, 16'h3012, 1'b0, 4'd5}, // R5 return
    '{16'h4801, 16'h3012, 16'h0000, 3'b000, 16'h3013, 1'b1, 4'd6}, // R6 +1
    '{16'h4C00, 16'h0100, 16'h0000, 3'b000, 16'hFD00, 1'b1, 4'd9}, // R9 -1024 wrap
    '{16'h4BFF, 16'hFF00, 16'h0000, 3'b000, 16'h02FF, 1'b1, 4'd9}, // R9 +1023 wrap
    '{16'h40C0, 16'h2000, 16'h5555, 3'b000, 16'h5555, 1'b1, 4'd7}, // R7 via r3
    '{16'h41C0, 16'h4000, 16'h1234, 3'b000, 16'h1234, 1'b1, 4'd7}, // R7 via r7
    '{16'h1021, 16'h3001, 16'hAAAA, 3'b111, 16'h3001, 1'b0, 4'd8}, // R8 add
    '{16'h25FC, 16'h300D, 16'h0000, 3'b001, 16'h300D, 1'b0, 4'd8}, // R8 load
    '{16'hF025, 16'h3456, 16'h9999, 3'b100, 16'h3456, 1'b0, 4'd8}, // R8 trap
    '{16'h8000, 16'h0042, 16'h7777, 3'b010, 16'h0042, 1'b0, 4'd8}, // R8 rti
    '{16'h0A04, 16'h0200, 16'h0000, 3'b010, 16'h0200, 1'b0, 4'd4}, // R4 np vs z
    '{16'h0A04, 16'h0200, 16'h0000, 3'b100, 16'h0204, 1'b0, 4'd3}  // R3 np vs n
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [15:0] in_instr = '0;
  logic [PC_W-1:0] in_pc_inc = '0, in_base = '0;
  logic [2:0] in_flags = '0;
  logic in_ready, out_valid, out_link_we;
  logic [2:0] base_idx;
  logic [PC_W-1:0] out_next_pc, out_link_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextpc_unit #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc_inc(in_pc_inc), .in_base(in_base),
    .in_flags(in_flags), .base_idx(base_idx), .out_valid(out_valid),
    .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_link_we(out_link_we), .out_link_data(out_link_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] ins, input logic [15:0] pc,
                       input logic [15:0] b, input logic [2:0] f);
    in_instr = ins; in_pc_inc = pc; in_base = b; in_flags = f; in_valid = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 out_valid in reset", {31'd0, out_valid}, 0);
    chk("R2 in_ready in reset", {31'd0, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 out_valid after reset", {31'd0, out_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      drive(VECS[i].instr, VECS[i].pc, VECS[i].base, VECS[i].fl);
      #1;
      // R5: base index field instr[8:6]
      chk({tag, " base_idx R5"}, {29'd0, base_idx}, {29'd0, VECS[i].instr[8:6]});
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid R1"}, {31'd0, out_valid}, 1);
      chk({tag, " next_pc"}, {16'd0, out_next_pc}, {16'd0, VECS[i].exp_pc});
      chk({tag, " link_we"}, {31'd0, out_link_we}, {31'd0, VECS[i].exp_we});
      if (VECS[i].exp_we)
        chk({tag, " link_data"}, {16'd0, out_link_data}, {16'd0, VECS[i].pc});
    end
    @(negedge clk);
    chk("R1 drained", {31'd0, out_valid}, 0);

    // R1 back-pressure: hold result, refuse input
    out_ready = 1'b0;
    drive(16'hC180, 16'h0010, 16'hBEEF, 3'b000);
    @(negedge clk);
    drive(16'h4801, 16'h0020, 16'h0000, 3'b000);
    chk("R1 in_ready low when full", {31'd0, in_ready}, 0);
    repeat (2) @(negedge clk);
    chk("R1 held next_pc", {16'd0, out_next_pc}, 32'h0000BEEF);
    chk("R1 held link_we", {31'd0, out_link_we}, 0);
    out_ready = 1'b1;
    #1;
    chk("R1 in_ready when draining", {31'd0, in_ready}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 after stall next_pc", {16'd0, out_next_pc}, 32'h00000021);
    chk("R6 after stall link_we", {31'd0, out_link_we}, 1);

    // R2 reset while holding a result
    out_ready = 1'b0;
    drive(16'hC1C0, 16'h0001, 16'h0123, 3'b000);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 pre-reset valid", {31'd0, out_valid}, 1);
    rst_n = 1'b0;
    #1;
    chk("R2 mid-run reset clears", {31'd0, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R2 stays empty", {31'd0, out_valid}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule